// File: doc/BRIEF.md
# Selective-Wake Frame Error Counter Controller

This block keeps the frame error count that a selective-wake CAN monitor uses to decide whether the bus is healthy. A frame decoder, outside this block, reports each finished frame with a single-cycle pulse. The pulse says whether the frame was a correct classic frame, a corrupted frame, or a flexible-data-rate (FD) frame. Two control bits choose how those pulses move the count. One is a level input that enables FD tolerance. The other is an error-count disable bit held inside the block. A bus-silence timer pulse clears that disable bit automatically.

The count climbs on bad traffic and falls on good traffic. When a climb reaches the overflow limit, a sticky overflow flag is raised to request a wake-up. With both control bits set, the count is forced to zero and held there. This lets a node be reprogrammed over the bus with FD traffic without ever reaching overflow.

Top module: `swk_errcnt_ctrl`

## Requirements
- R1: With both `fd_tol_en` and the disable bit low, a `frm_err` or `frm_fd` pulse adds one to `err_cnt` and a `frm_ok` pulse subtracts one. When several pulses arrive in one cycle, `frm_err` outranks `frm_fd`, which outranks `frm_ok`.
- R2: With the disable bit high and `fd_tol_en` low, counting follows R1 exactly.
- R3: With `fd_tol_en` high and the disable bit low, `frm_ok` and `frm_fd` each subtract one and `frm_err` adds one. An FD frame therefore never raises the count.
- R4: With `fd_tol_en` high and the disable bit high, `err_cnt` is zero from the next edge on and stays zero. Frame pulses are ignored and the flag never sets.
- R5: A `cnt_dis_wr` pulse loads `cnt_dis_wdata` into the disable bit, which shows on `cnt_dis` after the edge. A `silence_exp` pulse clears the bit and wins over a write in the same cycle.
- R6: A decrement at zero leaves zero. An increment at the top value 2^CNT_W-1 leaves that value.
- R7: `ovf_flag` rises at the edge where an increment brings `err_cnt` to OVF_LIMIT (32 by default) or higher. It then stays high while the count falls.
- R8: `ovf_clr` clears `ovf_flag` and wins over a set in the same cycle. `cnt_clr` zeroes `err_cnt` and clears `ovf_flag` at the next edge, ahead of any frame pulse.
- R9: After reset, `err_cnt`, `ovf_flag` and `cnt_dis` are zero. Every update appears on the outputs at the first clock edge after the causing pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fd_tol_en | input | 1 | FD-tolerant counting policy enable (level) |
| cnt_dis_wr | input | 1 | Write strobe for the disable bit |
| cnt_dis_wdata | input | 1 | Value written into the disable bit |
| silence_exp | input | 1 | Bus-silence timeout pulse; clears the disable bit |
| frm_ok | input | 1 | Correct classic frame received (pulse) |
| frm_err | input | 1 | Corrupted frame received (pulse) |
| frm_fd | input | 1 | FD frame detected (pulse) |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_clr | input | 1 | Clears the counter and the overflow flag |
| err_cnt | output | CNT_W | Current error count |
| ovf_flag | output | 1 | Sticky overflow / wake request flag |
| cnt_dis | output | 1 | Current state of the disable bit |

## Verification
The bench builds the block with CNT_W = 6 and OVF_LIMIT = 32, the default values. The power-of-two limit selects the bit-test comparator variant. The top value 63 is only 63 error pulses from zero, so a directed climb reaches both the flag threshold and the upper saturation point. Random phases of error-heavy and good-heavy traffic push the count up and down through 32 many times. Those phases also toggle the policy bits, overlap silence expiry with disable writes, and overlap clears with increments.

// File: rtl/swk_errcnt_pkg.sv
package swk_errcnt_pkg;

   // counting policy, indexed by {disable bit, fd-tolerant bit}
   typedef enum logic [1:0] {
      POL_STD      = 2'b00,
      POL_FD_TOL   = 2'b01,
      POL_STD_DIS  = 2'b10,
      POL_PROG     = 2'b11
   } swk_policy_e;

   typedef struct packed {
      logic force_zero;
      logic step_up;
      logic step_dn;
   } swk_step_t;

endpackage

// File: rtl/swk_policy_dec.sv
module swk_policy_dec
   import swk_errcnt_pkg::*;
(
   input  logic      fd_tol,
   input  logic      dis,
   input  logic      ev_ok,
   input  logic      ev_err,
   input  logic      ev_fd,
   output swk_step_t step
);
   swk_policy_e mode;
   logic        fd_is_bad;

   assign mode = swk_policy_e'({dis, fd_tol});

   always_comb begin
      fd_is_bad       = 1'b1;
      step.force_zero = 1'b0;
      unique case (mode)
         POL_STD, POL_STD_DIS: fd_is_bad = 1'b1;
         POL_FD_TOL:           fd_is_bad = 1'b0;
         POL_PROG: begin
            fd_is_bad       = 1'b0;
            step.force_zero = 1'b1;
         end
         default:              fd_is_bad = 1'b1;
      endcase
      // corrupted frames outrank FD frames, which outrank good frames
      step.step_up = ev_err | (ev_fd & fd_is_bad);
      step.step_dn = ~ev_err & ((ev_fd & ~fd_is_bad) | (~ev_fd & ev_ok));
   end
endmodule

// File: rtl/swk_err_counter.sv
module swk_err_counter
   import swk_errcnt_pkg::*;
#(
   parameter int CNT_W = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  swk_step_t        step,
   input  logic             sw_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_nx,
   output logic             up_taken
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   always_comb begin
      cnt_nx   = cnt_q;
      up_taken = 1'b0;
      if (sw_clr || step.force_zero) begin
         cnt_nx = '0;
      end else if (step.step_up) begin
         up_taken = 1'b1;
         if (cnt_q != CNT_TOP) cnt_nx = cnt_q + 1'b1;
      end else if (step.step_dn && cnt_q != '0) begin
         cnt_nx = cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nx;
   end

   p_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step.force_zero |=> cnt_q == '0);
   p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !step.step_up) |=> cnt_q == '0);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr |=> cnt_q == '0);
   p_unit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_clr && !step.force_zero) |=>
         (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 ||
          cnt_q + 1'b1 == $past(cnt_q)));
endmodule

// File: rtl/swk_ovf_flag.sv
module swk_ovf_flag #(
   parameter int CNT_W     = 6,
   parameter int OVF_LIMIT = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nx,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             up_taken,
   input  logic             flag_clr,
   input  logic             sw_clr,
   output logic             ovf_q
);
   localparam bit                LIM_POW2 = (OVF_LIMIT & (OVF_LIMIT - 1)) == 0;
   localparam logic [CNT_W-1:0]  LIM_V    = CNT_W'(OVF_LIMIT);

   logic reach;

   generate
      if (LIM_POW2) begin : g_bit_test
         localparam int LB = $clog2(OVF_LIMIT);
         assign reach = |cnt_nx[CNT_W-1:LB];
      end else begin : g_compare
         assign reach = cnt_nx >= LIM_V;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ovf_q <= 1'b0;
      else if (flag_clr || sw_clr) ovf_q <= 1'b0;
      else if (up_taken && reach)  ovf_q <= 1'b1;
   end

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !flag_clr && !sw_clr) |=> ovf_q);
   p_ovf_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> cnt_q >= LIM_V);
   p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr || sw_clr) |=> !ovf_q);
endmodule

// File: rtl/swk_errcnt_ctrl.sv
module swk_errcnt_ctrl
   import swk_errcnt_pkg::*;
#(
   parameter int CNT_W     = 6,
   parameter int OVF_LIMIT = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fd_tol_en,
   input  logic             cnt_dis_wr,
   input  logic             cnt_dis_wdata,
   input  logic             silence_exp,
   input  logic             frm_ok,
   input  logic             frm_err,
   input  logic             frm_fd,
   input  logic             ovf_clr,
   input  logic             cnt_clr,
   output logic [CNT_W-1:0] err_cnt,
   output logic             ovf_flag,
   output logic             cnt_dis
);
   generate
      if (CNT_W < 2)
         $error("swk_errcnt_ctrl: CNT_W must be at least 2");
      if (OVF_LIMIT < 1 || OVF_LIMIT > (2**CNT_W) - 1)
         $error("swk_errcnt_ctrl: OVF_LIMIT must lie in 1 .. 2**CNT_W-1");
   endgenerate

   swk_step_t        step;
   logic [CNT_W-1:0] cnt_nx;
   logic             up_taken;
   logic             dis_q;

   // disable bit: silence expiry outranks a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dis_q <= 1'b0;
      else if (silence_exp) dis_q <= 1'b0;
      else if (cnt_dis_wr)  dis_q <= cnt_dis_wdata;
   end

   swk_policy_dec i_pol (
      .fd_tol (fd_tol_en),
      .dis    (dis_q),
      .ev_ok  (frm_ok),
      .ev_err (frm_err),
      .ev_fd  (frm_fd),
      .step   (step)
   );

   swk_err_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .sw_clr   (cnt_clr),
      .cnt_q    (err_cnt),
      .cnt_nx   (cnt_nx),
      .up_taken (up_taken)
   );

   swk_ovf_flag #(.CNT_W(CNT_W), .OVF_LIMIT(OVF_LIMIT)) i_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_nx   (cnt_nx),
      .cnt_q    (err_cnt),
      .up_taken (up_taken),
      .flag_clr (ovf_clr),
      .sw_clr   (cnt_clr),
      .ovf_q    (ovf_flag)
   );

   assign cnt_dis = dis_q;

   p_silence_r5: assert property (@(posedge clk) disable iff (!rst_n)
      silence_exp |=> !cnt_dis);
   p_prog_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_dis && fd_tol_en && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/test_swk_errcnt_ctrl.sv
module test_swk_errcnt_ctrl;
   localparam int CNT_W = 6;
   localparam int LIM   = 32;
   localparam int TOP   = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fd_tol_en = 0, cnt_dis_wr = 0, cnt_dis_wdata = 0, silence_exp = 0;
   logic frm_ok = 0, frm_err = 0, frm_fd = 0, ovf_clr = 0, cnt_clr = 0;
   logic [CNT_W-1:0] err_cnt;
   logic ovf_flag, cnt_dis;

   int n_run = 0, n_fail = 0;
   int m_cnt = 0;
   bit m_ovf = 0, m_dis = 0;

   always #2 clk = ~clk;

   swk_errcnt_ctrl #(.CNT_W(CNT_W), .OVF_LIMIT(LIM)) i_swk_errcnt_ctrl (
      .clk(clk), .rst_n(rst_n), .fd_tol_en(fd_tol_en), .cnt_dis_wr(cnt_dis_wr),
      .cnt_dis_wdata(cnt_dis_wdata), .silence_exp(silence_exp), .frm_ok(frm_ok),
      .frm_err(frm_err), .frm_fd(frm_fd), .ovf_clr(ovf_clr), .cnt_clr(cnt_clr),
      .err_cnt(err_cnt), .ovf_flag(ovf_flag), .cnt_dis(cnt_dis)
   );

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      check(tag, int'(err_cnt), m_cnt, "err_cnt");
      check(tag, int'(ovf_flag), int'(m_ovf), "ovf_flag");
      check(tag, int'(cnt_dis), int'(m_dis), "cnt_dis");
   endtask

   // model of one clock edge, written from the requirements
   task automatic model_step();
      bit force0, up, dn, fdbad;
      int nc;
      force0 = m_dis && fd_tol_en;
      fdbad  = !fd_tol_en;
      up = !force0 && (frm_err || (frm_fd && fdbad));
      dn = !force0 && !frm_err && ((frm_fd && !fdbad) || (!frm_fd && frm_ok));
      nc = m_cnt;
      if (cnt_clr || force0) nc = 0;
      else if (up) nc = (m_cnt == TOP) ? TOP : m_cnt + 1;
      else if (dn) nc = (m_cnt == 0) ? 0 : m_cnt - 1;
      if (cnt_clr || ovf_clr) m_ovf = 0;
      else if (up && !cnt_clr && nc >= LIM) m_ovf = 1;
      m_cnt = nc;
      if (silence_exp) m_dis = 0;
      else if (cnt_dis_wr) m_dis = cnt_dis_wdata;
   endtask

   // drive at negedge, model the edge, compare at next negedge
   task automatic cyc(input bit ok, input bit err, input bit fd, input bit wr,
                      input bit wd, input bit sil, input bit oc, input bit cc,
                      input string tag);
      frm_ok = ok; frm_err = err; frm_fd = fd; cnt_dis_wr = wr; cnt_dis_wdata = wd;
      silence_exp = sil; ovf_clr = oc; cnt_clr = cc;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input string tag);
      cyc(0,0,0,0,0,0,0,0,tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      compare("R9");                          // reset state
      rst_n = 1'b1;
      @(negedge clk);
      // R1: default policy
      repeat (3) cyc(0,1,0,0,0,0,0,0,"R1");   // 3
      cyc(0,0,1,0,0,0,0,0,"R1");              // 4
      cyc(1,0,0,0,0,0,0,0,"R1");              // 3
      cyc(1,1,1,0,0,0,0,0,"R1");              // err wins: 4
      cyc(1,0,1,0,0,0,0,0,"R1");              // fd wins: 5
      // R5/R2: disable bit only
      cyc(0,0,0,1,1,0,0,0,"R5");
      cyc(0,0,1,0,0,0,0,0,"R2");              // 6
      cyc(1,0,0,0,0,0,0,0,"R2");              // 5
      cyc(0,0,0,0,0,1,0,0,"R5");              // silence clears
      cyc(0,0,0,1,1,1,0,0,"R5");              // silence beats write
      // R3: fd tolerant
      fd_tol_en = 1;
      cyc(0,0,1,0,0,0,0,0,"R3");              // 4
      cyc(0,1,0,0,0,0,0,0,"R3");              // 5
      cyc(1,0,0,0,0,0,0,0,"R3");              // 4
      // R6 floor
      repeat (8) cyc(1,0,0,0,0,0,0,0,"R6");
      // R7 climb to threshold and beyond
      fd_tol_en = 0;
      repeat (31) cyc(0,1,0,0,0,0,0,0,"R7");
      check("R7", int'(ovf_flag), 0, "flag below limit");
      cyc(0,1,0,0,0,0,0,0,"R7");
      check("R7", int'(ovf_flag), 1, "flag at limit");
      repeat (40) cyc(0,1,0,0,0,0,0,0,"R6");  // saturate at top
      check("R6", int'(err_cnt), TOP, "top saturation");
      repeat (50) cyc(1,0,0,0,0,0,0,0,"R7");  // sticky while falling
      // R8: clear beats set, counter clear beats event
      repeat (40) cyc(0,1,0,0,0,0,0,0,"R8");
      cyc(0,1,0,0,0,0,1,0,"R8");
      cyc(0,1,0,0,0,0,0,1,"R8");
      check("R8", int'(err_cnt), 0, "cleared count");
      // R4: programming hold
      repeat (5) cyc(0,1,0,0,0,0,0,0,"R4");
      fd_tol_en = 1;
      cyc(0,0,0,1,1,0,0,0,"R4");
      repeat (40) cyc(0,1,1,0,0,0,0,0,"R4");
      check("R4", int'(err_cnt), 0, "held zero");
      cyc(0,0,0,0,0,1,0,0,"R5");
      idle("R9");
      // random phases
      for (int i = 0; i < 4000; i++) begin
         int pe;
         bit e, o, f, w, wd, s, oc, cc;
         if (i % 700 == 0) fd_tol_en = $urandom_range(1, 0);
         pe = ((i / 400) % 2 == 0) ? 55 : 15;
         e  = $urandom_range(99, 0) < pe;
         f  = $urandom_range(99, 0) < 20;
         o  = $urandom_range(99, 0) < 50;
         w  = $urandom_range(79, 0) == 0;
         wd = $urandom_range(1, 0);
         s  = $urandom_range(99, 0) == 0;
         oc = $urandom_range(59, 0) == 0;
         cc = $urandom_range(299, 0) == 0;
         cyc(o, e, f, w, wd, s, oc, cc, "R9");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule